// File: doc/BRIEF.md
# DRAM Controller Register Stub

This block stands in for a DRAM controller while boot firmware brings the chip up. It gives the firmware three register windows of 4 KiB each: a common window, a controller window and a PHY window. Each window is a flat array of 32-bit words, and the number of words in each window is a parameter. A simple word bus reaches all three windows. The bus carries a window select, a byte address, a write enable, write data and a combinational read data return.

The block has no DRAM timing, no training and no data path. It has two behaviours beyond plain storage:

- **PHY-init completion.** A write to the PHY-initialisation register at controller offset 0x00 sets the init-done flag and the controller-active flag in the same clock edge. Firmware that polls for training to finish therefore exits its loop at once.
- **Control register decode.** A write to the common control register at common offset 0x00 sends a one-cycle pulse to a neighbouring address-aliasing unit. The decoded row-bit, bank-bit and page-size values of the stored control word are exported alongside the pulse.

Top module: `dramc_boot_stub`

## Requirements
- R1: After reset, every register of every window reads zero. `map_pulse` is 0, and the decoded outputs show the values for a zero control word: row bits 1, bank bits 2, page 8 bytes.
- R2: The window select picks the window: 0 is common, 1 is controller, 2 is PHY. The register index is `addr[11:2]`. An accepted write stores `wdata` at the rising edge. A read returns the stored word on `rdata` combinationally.
- R3: When the index is equal to or greater than the selected window's register count, a read returns zero and a write changes no register.
- R4: An access is accepted only when `addr[1:0]` is 0 and the window select is 0, 1 or 2. Any other access reads zero and a write to it changes nothing.
- R5: An accepted write to controller index 0 stores `wdata` there. In the same edge it sets bit 0 of controller index 4 (byte 0x10) and bit 0 of controller index 6 (byte 0x18). Bits 31:1 of those two registers keep their values.
- R6: Writes to any other controller register, and to any PHY register, are plain stores. They touch no other register.
- R7: For each accepted write to common index 0, `map_pulse` is 1 for exactly the cycle after that write's edge. In that cycle the decoded outputs show the new word.
- R8: The decoded outputs always follow the stored common index 0 word `c`: `map_row_bits` = `c[7:4]`+1, `map_bank_bits` = `c[2]`+2, `map_page_bytes` = 1 << (`c[11:8]`+3).
- R9: Writes to other common registers, and rejected writes aimed at common offset 0, give no pulse.
- R10: Asserting reset in the middle of operation clears all windows at once, and the pulse with them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_sel | input | 2 | Window select: 0 common, 1 controller, 2 PHY |
| addr | input | 12 | Byte offset inside the window |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current `win_sel`/`addr` |
| map_pulse | output | 1 | One-cycle pulse after each accepted control-register write |
| map_row_bits | output | 5 | Decoded row address bits |
| map_bank_bits | output | 2 | Decoded bank address bits |
| map_page_bytes | output | 19 | Decoded page size in bytes |

## Verification
The bench builds the block with 4 common, 8 controller and 5 PHY registers. With counts this small, every register of every window can be written and read back. The first index past each window's end is reached on both sides of the bound, and so are indices far beyond it. The controller window of 8 still holds both status registers, so the completion flags can be preset with other bits and checked for preservation. A small common window places the non-control neighbours right next to the control register, where a false pulse would show.

// File: rtl/dramc_boot_stub.sv
module dramc_boot_stub #(
  parameter int COM_REGS  = 16,
  parameter int CTL_REGS  = 64,
  parameter int PHY_REGS  = 64,
  parameter int WIN_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  win_sel,
  input  logic [11:0] addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        map_pulse,
  output logic [4:0]  map_row_bits,
  output logic [1:0]  map_bank_bits,
  output logic [18:0] map_page_bytes
);
  localparam int AW     = $clog2(WIN_BYTES);
  localparam int IW     = AW - 2;
  localparam int PIR_IX = 0;
  localparam int PGS_IX = 4;
  localparam int STA_IX = 6;
  localparam int CR_IX  = 0;

  logic [31:0] com_q [COM_REGS];
  logic [31:0] ctl_q [CTL_REGS];
  logic [31:0] phy_q [PHY_REGS];
  logic        pulse_q;

  wire [IW-1:0] idx     = addr[AW-1:2];
  wire          aligned = (addr[1:0] == 2'b00);
  wire          wr_ok   = wr_en && aligned;
  wire          com_wr  = wr_ok && (win_sel == 2'd0);
  wire          ctl_wr  = wr_ok && (win_sel == 2'd1);
  wire          phy_wr  = wr_ok && (win_sel == 2'd2);
  wire          cr_wr   = com_wr && (idx == IW'(CR_IX));
  wire          pir_wr  = ctl_wr && (idx == IW'(PIR_IX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < COM_REGS; i++) com_q[i] <= '0;
    end else begin
      for (int i = 0; i < COM_REGS; i++)
        if (com_wr && idx == IW'(i)) com_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CTL_REGS; i++) ctl_q[i] <= '0;
    end else begin
      for (int i = 0; i < CTL_REGS; i++) begin
        if (ctl_wr && idx == IW'(i))
          ctl_q[i] <= wdata;
        else if (pir_wr && (i == PGS_IX || i == STA_IX))
          ctl_q[i][0] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHY_REGS; i++) phy_q[i] <= '0;
    end else begin
      for (int i = 0; i < PHY_REGS; i++)
        if (phy_wr && idx == IW'(i)) phy_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= cr_wr;
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (win_sel)
        2'd0: for (int i = 0; i < COM_REGS; i++) if (idx == IW'(i)) rdata = com_q[i];
        2'd1: for (int i = 0; i < CTL_REGS; i++) if (idx == IW'(i)) rdata = ctl_q[i];
        2'd2: for (int i = 0; i < PHY_REGS; i++) if (idx == IW'(i)) rdata = phy_q[i];
        default: rdata = '0;
      endcase
    end
  end

  wire [31:0] cr = com_q[CR_IX];

  assign map_pulse      = pulse_q;
  assign map_row_bits   = {1'b0, cr[7:4]} + 5'd1;
  assign map_bank_bits  = {1'b0, cr[2]} + 2'd2;
  assign map_page_bytes = 19'd1 << ({1'b0, cr[11:8]} + 5'd3);

  // R5: completion flags rise on the PHY-init write and the word is kept
  a_r5_pir_flags: assert property (@(posedge clk) disable iff (!rst_n)
    pir_wr |=> (ctl_q[PGS_IX][0] && ctl_q[STA_IX][0] && ctl_q[PIR_IX] == $past(wdata)));

  a_r5_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
    pir_wr |=> (ctl_q[PGS_IX][31:1] == $past(ctl_q[PGS_IX][31:1]) &&
                ctl_q[STA_IX][31:1] == $past(ctl_q[STA_IX][31:1])));

  // R6: PHY stores leave controller status alone
  a_r6_phy_plain: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr |=> ($stable(ctl_q[PGS_IX]) && $stable(ctl_q[STA_IX])));

  // R7: pulse only follows an accepted control write, carrying its decode
  a_r7_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    map_pulse |-> $past(cr_wr));

  a_r7_pulse_decode: assert property (@(posedge clk) disable iff (!rst_n)
    map_pulse |-> (map_row_bits == {1'b0, $past(wdata[7:4])} + 5'd1));

  // R3/R4: rejected reads return zero
  a_r4_unaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!aligned || win_sel == 2'd3) |-> (rdata == 32'd0));

  a_r3_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sel == 2'd2 && int'(idx) >= PHY_REGS) |-> (rdata == 32'd0));
endmodule

// File: tb/dramc_boot_stub_tb.sv
module dramc_boot_stub_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NT = 8;
  localparam int NP = 5;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  win_sel = 0;
  logic [11:0] addr = 0;
  logic        wr_en = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        map_pulse;
  logic [4:0]  map_row_bits;
  logic [1:0]  map_bank_bits;
  logic [18:0] map_page_bytes;

  dramc_boot_stub #(.COM_REGS(NC), .CTL_REGS(NT), .PHY_REGS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .map_pulse(map_pulse), .map_row_bits(map_row_bits),
    .map_bank_bits(map_bank_bits), .map_page_bytes(map_page_bytes));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  string tag = "R1";

  logic [31:0] m_com [NC];
  logic [31:0] m_ctl [NT];
  logic [31:0] m_phy [NP];
  bit m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) m_com[i] = 0;
      for (int i = 0; i < NT; i++) m_ctl[i] = 0;
      for (int i = 0; i < NP; i++) m_phy[i] = 0;
      m_pulse = 0;
    end else begin
      int ix;
      ix = int'(addr) / 4;
      m_pulse = 0;
      if (wr_en && addr[1:0] == 2'b00) begin
        if (win_sel == 0 && ix < NC) begin
          m_com[ix] = wdata;
          if (ix == 0) m_pulse = 1;
        end else if (win_sel == 1 && ix < NT) begin
          m_ctl[ix] = wdata;
          if (ix == 0) begin
            m_ctl[4] = m_ctl[4] | 32'd1;
            m_ctl[6] = m_ctl[6] | 32'd1;
          end
        end else if (win_sel == 2 && ix < NP) begin
          m_phy[ix] = wdata;
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] s, input logic [11:0] a);
    int ix;
    ix = int'(a) / 4;
    if (a[1:0] != 2'b00) return 0;
    case (s)
      2'd0: return (ix < NC) ? m_com[ix] : 32'd0;
      2'd1: return (ix < NT) ? m_ctl[ix] : 32'd0;
      2'd2: return (ix < NP) ? m_phy[ix] : 32'd0;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] c;
      c = m_com[0];
      check("rdata", rdata, exp_rd(win_sel, addr));
      check("pulse", map_pulse, m_pulse);
      check("row_bits", map_row_bits, c[7:4] + 1);
      check("bank_bits", map_bank_bits, c[2] + 2);
      check("page_bytes", map_page_bytes, 1 << (c[11:8] + 3));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drv(input logic [1:0] s, input int a, input logic [31:0] d, input bit w);
    @(posedge clk); #1;
    win_sel = s; addr = 12'(a); wdata = d; wr_en = w;
  endtask

  task automatic scan(input logic [1:0] s, input int n);
    for (int i = 0; i < n + 2; i++) drv(s, i * 4, 32'h0, 0);
  endtask

  initial begin
    tag = "R1";
    drv(0, 0, 0, 0); drv(1, 0, 0, 0);
    #1 rst_n = 1;
    scan(0, NC); scan(1, NT); scan(2, NP);

    tag = "R2";
    for (int i = 1; i < NC; i++) drv(0, i * 4, 32'hC0DE_0000 + i, 1);
    for (int i = 1; i < NT; i++) drv(1, i * 4, 32'h5A00_0000 ^ (i * 32'h1111), 1);
    for (int i = 0; i < NP; i++) drv(2, i * 4, ~(32'h1 << i), 1);
    scan(0, NC); scan(1, NT); scan(2, NP);

    tag = "R3";
    drv(0, NC * 4, 32'hDEAD_0001, 1);
    drv(1, NT * 4, 32'hDEAD_0002, 1);
    drv(2, NP * 4, 32'hDEAD_0003, 1);
    drv(2, (NP + 3) * 4, 32'hDEAD_0004, 1);
    drv(2, 1023 * 4, 32'hDEAD_0005, 1);
    scan(0, NC); scan(1, NT); scan(2, NP);

    tag = "R4";
    drv(2, 5, 32'hBAD0_0001, 1);
    drv(1, 2, 32'hBAD0_0002, 1);
    drv(3, 0, 32'hBAD0_0003, 1);
    drv(3, 4, 32'hBAD0_0004, 1);
    drv(3, 4, 0, 0);
    scan(2, NP); scan(1, NT);

    tag = "R5";
    drv(1, 16, 32'hA5A5_A5A4, 1);
    drv(1, 24, 32'h0F0F_F0F0, 1);
    drv(1, 0, 32'h0000_1234, 1);
    drv(1, 16, 0, 0); drv(1, 24, 0, 0); drv(1, 0, 0, 0);
    drv(1, 0, 32'hFFFF_0000, 1);
    scan(1, NT);

    tag = "R6";
    drv(1, 16, 32'h0000_0000, 1);
    drv(1, 24, 32'h8000_0000, 1);
    drv(1, 8, 32'h1357_9BDF, 1);
    drv(2, 0, 32'h2468_ACE0, 1);
    drv(2, 16, 32'hFFFF_FFFF, 1);
    scan(1, NT); scan(2, NP);

    tag = "R7";
    drv(0, 0, 32'h0000_0FF4, 1);
    drv(0, 0, 0, 0);
    drv(0, 0, 32'h0000_03A0, 1);
    drv(0, 0, 32'h0000_0754, 1);
    drv(0, 0, 0, 0); drv(0, 0, 0, 0);

    tag = "R8";
    for (int p = 0; p < 16; p++) begin
      drv(0, 0, {20'h0, 4'(p), 4'(15 - p), 1'b0, 1'(p), 2'b11}, 1);
      drv(0, 0, 0, 0);
    end

    tag = "R9";
    drv(0, 4, 32'h0000_0F00, 1);
    drv(0, 12, 32'h0000_00F0, 1);
    drv(0, 1, 32'h0000_0FFF, 1);
    drv(0, 2, 32'h0000_0FFF, 1);
    drv(3, 0, 32'h0000_0FFF, 1);
    drv(0, NC * 4, 32'h0000_0FFF, 1);
    drv(0, 0, 0, 0);

    tag = "R10";
    drv(0, 0, 32'h0000_0AB4, 1);
    @(posedge clk); #1;
    rst_n = 0; wr_en = 0;
    @(posedge clk); #1;
    rst_n = 1;
    scan(0, NC); scan(1, NT); scan(2, NP);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule